// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps the time of day (seconds, minutes, hours) and the date (century, year, month, day of week, day of month) as packed BCD. It advances by one second on each single-cycle `tick` pulse. A one-second strobe produced elsewhere drives `tick`. The block resolves every carry itself: seconds into minutes into hours into the date, month lengths, the leap-year rule and the year and century rollover.

Software uses a small word-addressed register bus. To set the clock it raises a request bit for the time part, the calendar part or both. It waits for an acknowledge flag, writes the new values and then drops the request bits. A three-state handshake machine governs this sequence. In `UPD_IDLE` no part is held. When a request bit goes high the machine moves to `UPD_ARMED`. From `UPD_ARMED`, the first `tick` moves it to `UPD_HELD`, and that same tick sets the acknowledge flag. If every request bit drops while the machine is in `UPD_ARMED` or `UPD_HELD`, it returns to `UPD_IDLE`. Three sticky event flags report a second step, a minute change and a date change. Software clears each flag by writing 1 to its bit in a clear register.

Register word addresses: 0 control, 1 time, 2 calendar, 3 status (read), 4 clear (write). Reads return 0 at unused addresses and in unused bits.

Top module: `rtcc_top`

## Requirements
- R1: After reset, the time register reads 0x00000000. The calendar register reads the reset date from the parameters: century 20, year 00, month 01, weekday 1, day 01. Status and control read 0.
- R2: Time register fields: seconds in bits 6:0, minutes in bits 14:8, hours in bits 21:16, all BCD. Seconds and minutes wrap from 59 to 00 and carry one step onward. Hours wrap from 23 to 00 and carry into the date.
- R3: Calendar register fields: century in bits 6:0, year in bits 15:8, month (1..12) in bits 20:16, weekday (1..7) in bits 23:21, day of month in bits 29:24, all BCD. The day of month wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00 and carries into the century.
- R4: February ends at 29 in a leap year and at 28 otherwise. A nonzero year is a leap year when its value is divisible by 4. Year 00 is a leap year only when the century is divisible by 4.
- R5: The weekday advances with each date change and wraps from 7 to 1.
- R6: Control bit 0 holds the time part still and control bit 1 holds the calendar part still, for as long as the bit is set. A held calendar ignores a midnight carry from a running time part.
- R7: Status bit 0 (acknowledge) rises only on the first tick after a request bit is set, never before.
- R8: A write to the time or calendar register takes effect only when that part's request bit is set and the acknowledge tick has occurred. Any other such write is ignored.
- R9: After the request bits are cleared, counting resumes from the values that were written.
- R10: Status bit 2 sets when the seconds step. Bit 3 sets when the minutes change. Bit 4 sets when the date changes. A held part raises none of its events.
- R11: Writing 1 to a bit of the clear register clears the matching status bit and leaves the others unchanged. If an event sets a flag in the same cycle that the flag is being cleared, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse per elapsed second |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The bench uses the default parameters. These are a 3-bit address and a reset date of century 20, year 00, January 1, weekday 1, so the first reads after reset have known expected values. Because `tick` is a plain input, the bench can drive it every other cycle. This puts rollovers at midnight, month end, year end and century end within one tick of a loaded value, and a 61-tick run reaches a minute carry. The vector table covers each month-length class and both leap-rule branches, including BCD years whose tens digit matters (10, 12).

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

    localparam int REG_W = 32;

    // word addresses
    localparam int A_CTRL = 0;
    localparam int A_TIME = 1;
    localparam int A_CAL  = 2;
    localparam int A_STAT = 3;
    localparam int A_CLR  = 4;

    // control / status bit positions
    localparam int CTRL_TIME = 0;
    localparam int CTRL_CAL  = 1;
    localparam int ST_ACK    = 0;
    localparam int ST_SEC    = 2;
    localparam int ST_MIN    = 3;
    localparam int ST_DAY    = 4;

    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,
        UPD_ARMED = 2'd1,
        UPD_HELD  = 2'd2
    } upd_state_e;

    // {carry, next}: wraps to 'first' after 'last', else BCD +1
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        if (v == last)
            return {1'b1, first};
        else if (v[3:0] >= 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    // BCD value divisible by four: (2*tens + ones) mod 4 == 0
    function automatic logic bcd_div4(input logic [7:0] b);
        return ((({b[7:4], 1'b0} + {1'b0, b[3:0]}) & 5'h03) == 5'h00);
    endfunction

    function automatic logic is_leap(input logic [7:0] cent, input logic [7:0] year);
        return (year == 8'h00) ? bcd_div4(cent) : bcd_div4(year);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                     return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                   return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtcc_upd_fsm.sv
module rtcc_upd_fsm
    import rtcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic req_i,
    output logic hold_o,
    output logic ack_set_o
);

    upd_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= UPD_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            UPD_IDLE:  if (req_i) st_d = UPD_ARMED;
            UPD_ARMED: begin
                if (!req_i)      st_d = UPD_IDLE;
                else if (tick_i) st_d = UPD_HELD;
            end
            UPD_HELD:  if (!req_i) st_d = UPD_IDLE;
            default:   st_d = UPD_IDLE;
        endcase
    end

    always_comb begin
        hold_o    = (st_q == UPD_HELD);
        ack_set_o = (st_q == UPD_ARMED) && req_i && tick_i;
    end

    AST_HOLD_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(tick_i))
        else $error("hold entered without a tick"); // R7

    AST_HOLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> $past(req_i))
        else $error("hold without pending request"); // R8

endmodule

// File: rtl/rtcc_tod.sv
module rtcc_tod
    import rtcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic            run_i,
    input  logic            load_i,
    input  logic [2:0][7:0] ld_i,      // [0] sec, [1] min, [2] hour
    output logic [31:0]     tim_o,
    output logic            sec_evt_o,
    output logic            min_evt_o,
    output logic            day_carry_o
);

    localparam int NFLD = 3;
    localparam logic [7:0] LAST_V [NFLD] = '{8'h59, 8'h59, 8'h23};

    logic [NFLD:0]   carry;
    logic [7:0]      fld [NFLD];

    assign carry[0] = step_i && run_i && !load_i;

    for (genvar i = 0; i < NFLD; i++) begin : g_fld
        logic [7:0] q;
        logic [8:0] nx;
        always_comb nx = bcd_step(q, LAST_V[i], 8'h00);
        assign carry[i+1] = carry[i] && nx[8];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= 8'h00;
            else if (load_i)   q <= ld_i[i];
            else if (carry[i]) q <= nx[7:0];
        end
        assign fld[i] = q;
    end

    assign tim_o       = {10'd0, fld[2][5:0], 1'b0, fld[1][6:0], 1'b0, fld[0][6:0]};
    assign sec_evt_o   = carry[0];
    assign min_evt_o   = carry[1];
    assign day_carry_o = carry[NFLD];

    logic unused_hi;
    assign unused_hi = ^{fld[0][7], fld[1][7], fld[2][7:6]};

    AST_TIME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(tim_o))
        else $error("time moved while held"); // R6

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && run_i && !load_i && tim_o[6:0] == 7'h59) |=> (tim_o[6:0] == 7'h00))
        else $error("seconds did not wrap"); // R2

endmodule

// File: rtl/rtcc_cal.sv
module rtcc_cal
    import rtcc_pkg::*;
#(
    parameter logic [7:0] RST_CENTURY = 8'h20,
    parameter logic [7:0] RST_YEAR    = 8'h00,
    parameter logic [7:0] RST_MONTH   = 8'h01,
    parameter logic [7:0] RST_DOW     = 8'h01,
    parameter logic [7:0] RST_DATE    = 8'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_i,
    input  logic        run_i,
    input  logic        load_i,
    input  logic [31:0] ld_i,
    output logic [31:0] cal_o,
    output logic        day_evt_o
);

    logic [7:0] cent_q, year_q, mon_q, dow_q, date_q;
    logic [8:0] cent_nx, year_nx, mon_nx, dow_nx, date_nx;
    logic [7:0] mlast;
    logic       leap, adv, date_end;

    always_comb begin
        leap     = is_leap(cent_q, year_q);
        mlast    = month_last(mon_q, leap);
        adv      = step_i && run_i && !load_i;
        date_end = (date_q >= mlast);
        date_nx  = bcd_step(date_q, mlast, 8'h01);
        dow_nx   = bcd_step(dow_q, 8'h07, 8'h01);
        mon_nx   = bcd_step(mon_q, 8'h12, 8'h01);
        year_nx  = bcd_step(year_q, 8'h99, 8'h00);
        cent_nx  = bcd_step(cent_q, 8'h79, 8'h00);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cent_q <= RST_CENTURY;
            year_q <= RST_YEAR;
            mon_q  <= RST_MONTH;
            dow_q  <= RST_DOW;
            date_q <= RST_DATE;
        end else if (load_i) begin
            cent_q <= {1'b0, ld_i[6:0]};
            year_q <= ld_i[15:8];
            mon_q  <= {3'b0, ld_i[20:16]};
            dow_q  <= {5'b0, ld_i[23:21]};
            date_q <= {2'b0, ld_i[29:24]};
        end else if (adv) begin
            dow_q  <= dow_nx[7:0];
            date_q <= date_end ? 8'h01 : date_nx[7:0];
            if (date_end) begin
                mon_q <= mon_nx[7:0];
                if (mon_nx[8]) begin
                    year_q <= year_nx[7:0];
                    if (year_nx[8]) cent_q <= cent_nx[7:0];
                end
            end
        end
    end

    assign cal_o     = {2'b0, date_q[5:0], dow_q[2:0], mon_q[4:0], year_q, 1'b0, cent_q[6:0]};
    assign day_evt_o = adv;

    logic unused_bits;
    assign unused_bits = ^{cent_nx[8], dow_nx[8], date_nx[8], ld_i[31:30], ld_i[7],
                           cent_q[7], mon_q[7:5], dow_q[7:3], date_q[7:6]};

    AST_CAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(cal_o))
        else $error("calendar moved while held"); // R6

    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && dow_q == 8'h07) |=> (dow_q == 8'h01))
        else $error("weekday did not wrap"); // R5

    AST_FEB_COMMON: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !leap && mon_q == 8'h02 && date_q == 8'h28) |=> (date_q == 8'h01 && mon_q == 8'h03))
        else $error("common-year February overran"); // R4

endmodule

// File: rtl/rtcc_top.sv
module rtcc_top
    import rtcc_pkg::*;
#(
    parameter int         ADDR_W      = 3,
    parameter logic [7:0] RST_CENTURY = 8'h20,
    parameter logic [7:0] RST_YEAR    = 8'h00,
    parameter logic [7:0] RST_MONTH   = 8'h01,
    parameter logic [7:0] RST_DOW     = 8'h01,
    parameter logic [7:0] RST_DATE    = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata
);

    localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_TIME = ADDR_W'(A_TIME);
    localparam logic [ADDR_W-1:0] AD_CAL  = ADDR_W'(A_CAL);
    localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] AD_CLR  = ADDR_W'(A_CLR);

    logic [1:0]  ctrl_q;
    logic        ack_q, sec_q, min_q, day_q;
    logic        hold, ack_set;
    logic        ld_time, ld_cal;
    logic        sec_evt, min_evt, day_carry, day_evt;
    logic [31:0] tim_v, cal_v;
    logic [4:0]  clr;
    logic        unused_wd;

    // ---------------- handshake ----------------
    rtcc_upd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .req_i     (|ctrl_q),
        .hold_o    (hold),
        .ack_set_o (ack_set)
    );

    assign ld_time = bus_wr && bus_addr == AD_TIME && hold && ctrl_q[CTRL_TIME];
    assign ld_cal  = bus_wr && bus_addr == AD_CAL  && hold && ctrl_q[CTRL_CAL];

    // ---------------- counters ----------------
    rtcc_tod u_tod (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (tick),
        .run_i       (!ctrl_q[CTRL_TIME]),
        .load_i      (ld_time),
        .ld_i        ({{2'b0, bus_wdata[21:16]}, {1'b0, bus_wdata[14:8]}, {1'b0, bus_wdata[6:0]}}),
        .tim_o       (tim_v),
        .sec_evt_o   (sec_evt),
        .min_evt_o   (min_evt),
        .day_carry_o (day_carry)
    );

    rtcc_cal #(
        .RST_CENTURY (RST_CENTURY),
        .RST_YEAR    (RST_YEAR),
        .RST_MONTH   (RST_MONTH),
        .RST_DOW     (RST_DOW),
        .RST_DATE    (RST_DATE)
    ) u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (day_carry),
        .run_i     (!ctrl_q[CTRL_CAL]),
        .load_i    (ld_cal),
        .ld_i      (bus_wdata),
        .cal_o     (cal_v),
        .day_evt_o (day_evt)
    );

    // ---------------- control and status ----------------
    assign clr = (bus_wr && bus_addr == AD_CLR) ? bus_wdata[4:0] : 5'd0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 2'b00;
            ack_q  <= 1'b0;
            sec_q  <= 1'b0;
            min_q  <= 1'b0;
            day_q  <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == AD_CTRL) ctrl_q <= bus_wdata[1:0];
            ack_q <= ack_set | (ack_q & ~clr[ST_ACK]);
            sec_q <= sec_evt | (sec_q & ~clr[ST_SEC]);
            min_q <= min_evt | (min_q & ~clr[ST_MIN]);
            day_q <= day_evt | (day_q & ~clr[ST_DAY]);
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AD_CTRL: bus_rdata = {30'd0, ctrl_q};
            AD_TIME: bus_rdata = tim_v;
            AD_CAL:  bus_rdata = cal_v;
            AD_STAT: bus_rdata = {27'd0, day_q, min_q, sec_q, 1'b0, ack_q};
            default: bus_rdata = '0;
        endcase
    end

    assign unused_wd = ^{bus_wdata[31:30], bus_wdata[7], clr[1]};

    AST_TIME_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AD_TIME && ctrl_q[CTRL_TIME] && !hold) |=> $stable(tim_v))
        else $error("time write taken before acknowledge"); // R8

    AST_ACK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(tick))
        else $error("acknowledge rose without tick"); // R7

    AST_SEC_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sec_evt |=> sec_q)
        else $error("second event flag lost"); // R10

endmodule

// File: tb/rtcc_top_tb.sv
module rtcc_top_tb;

    localparam logic [2:0] W_CTRL = 3'd0;
    localparam logic [2:0] W_TIME = 3'd1;
    localparam logic [2:0] W_CAL  = 3'd2;
    localparam logic [2:0] W_STAT = 3'd3;
    localparam logic [2:0] W_CLR  = 3'd4;

    function automatic logic [31:0] mk_cal(input logic [7:0] c, input logic [7:0] y,
                                           input logic [7:0] m, input logic [2:0] w,
                                           input logic [7:0] d);
        return {2'b00, d[5:0], w, m[4:0], y, 1'b0, c[6:0]};
    endfunction

    typedef struct packed {
        logic [31:0] t0;
        logic [31:0] c0;
        logic [7:0]  n;
        logic [31:0] t1;
        logic [31:0] c1;
    } vec_t;

    localparam logic [31:0] DC = mk_cal(8'h20, 8'h24, 8'h05, 3'd3, 8'h15);
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{32'h00123456, DC, 8'd1,  32'h00123457, DC},
        '{32'h00123459, DC, 8'd1,  32'h00123500, DC},
        '{32'h00125959, DC, 8'd1,  32'h00130000, DC},
        '{32'h00095959, DC, 8'd1,  32'h00100000, DC},
        '{32'h00000000, DC, 8'd61, 32'h00000101, DC},
        '{32'h00235959, mk_cal(8'h20,8'h24,8'h02,3'd7,8'h28), 8'd1, 32'h0, mk_cal(8'h20,8'h24,8'h02,3'd1,8'h29)},
        '{32'h00235959, mk_cal(8'h20,8'h23,8'h02,3'd2,8'h28), 8'd1, 32'h0, mk_cal(8'h20,8'h23,8'h03,3'd3,8'h01)},
        '{32'h00235959, mk_cal(8'h20,8'h24,8'h04,3'd4,8'h30), 8'd1, 32'h0, mk_cal(8'h20,8'h24,8'h05,3'd5,8'h01)},
        '{32'h00235959, mk_cal(8'h20,8'h24,8'h12,3'd2,8'h31), 8'd1, 32'h0, mk_cal(8'h20,8'h25,8'h01,3'd3,8'h01)},
        '{32'h00235959, mk_cal(8'h20,8'h99,8'h12,3'd5,8'h31), 8'd1, 32'h0, mk_cal(8'h21,8'h00,8'h01,3'd6,8'h01)},
        '{32'h00235959, mk_cal(8'h20,8'h00,8'h02,3'd1,8'h28), 8'd1, 32'h0, mk_cal(8'h20,8'h00,8'h02,3'd2,8'h29)},
        '{32'h00235959, mk_cal(8'h21,8'h00,8'h02,3'd1,8'h28), 8'd1, 32'h0, mk_cal(8'h21,8'h00,8'h03,3'd2,8'h01)},
        '{32'h00235959, mk_cal(8'h20,8'h24,8'h01,3'd3,8'h31), 8'd1, 32'h0, mk_cal(8'h20,8'h24,8'h02,3'd4,8'h01)},
        '{32'h00235959, mk_cal(8'h20,8'h24,8'h09,3'd7,8'h30), 8'd1, 32'h0, mk_cal(8'h20,8'h24,8'h10,3'd1,8'h01)},
        '{32'h00235959, mk_cal(8'h20,8'h12,8'h02,3'd6,8'h28), 8'd1, 32'h0, mk_cal(8'h20,8'h12,8'h02,3'd7,8'h29)},
        '{32'h00235959, mk_cal(8'h20,8'h10,8'h02,3'd6,8'h28), 8'd1, 32'h0, mk_cal(8'h20,8'h10,8'h03,3'd7,8'h01)},
        '{32'h00235959, mk_cal(8'h20,8'h19,8'h12,3'd3,8'h31), 8'd1, 32'h0, mk_cal(8'h20,8'h20,8'h01,3'd4,8'h01)},
        '{32'h00235959, mk_cal(8'h20,8'h24,8'h02,3'd4,8'h29), 8'd1, 32'h0, mk_cal(8'h20,8'h24,8'h03,3'd5,8'h01)}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtcc_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // full handshake: request both, wait for ack tick, write, release, clear flags
    task automatic load_regs(input logic [31:0] t, input logic [31:0] c);
        wr(W_CTRL, 32'h3);
        idle(2);
        pulse_tick();
        wr(W_TIME, t);
        wr(W_CAL, c);
        wr(W_CTRL, 32'h0);
        wr(W_CLR, 32'h1F);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(W_TIME, v); chk("R1 time", v, 32'h0);
        rd(W_CAL, v);  chk("R1 cal", v, mk_cal(8'h20, 8'h00, 8'h01, 3'd1, 8'h01));
        rd(W_STAT, v); chk("R1 status", v, 32'h0);
        rd(W_CTRL, v); chk("R1 ctrl", v, 32'h0);

        // table walk: R2 R3 R4 R5 R9
        for (int i = 0; i < NV; i++) begin
            load_regs(VECS[i].t0, VECS[i].c0);
            for (int k = 0; k < int'(VECS[i].n); k++) pulse_tick();
            rd(W_TIME, v); chk($sformatf("R2 R9 vec%0d time", i), v, VECS[i].t1);
            rd(W_CAL, v);  chk($sformatf("R3 R4 R5 vec%0d cal", i), v, VECS[i].c1);
        end

        // R8: write with no request is ignored
        wr(W_TIME, 32'h00111111);
        rd(W_TIME, v); chk("R8 unrequested time write", v, 32'h0);

        // R10: midnight raises all three events
        load_regs(32'h00235959, mk_cal(8'h20, 8'h24, 8'h03, 3'd1, 8'h10));
        pulse_tick();
        rd(W_STAT, v); chk("R10 events at midnight", v, 32'h1C);
        rd(W_CAL, v);  chk("R3 R5 date after midnight", v, mk_cal(8'h20, 8'h24, 8'h03, 3'd2, 8'h11));
        // R11: selective clear
        wr(W_CLR, 32'h04);
        rd(W_STAT, v); chk("R11 clear second flag only", v, 32'h18);
        // R11: set wins over clear in the same cycle
        @(negedge clk);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = W_CLR; bus_wdata = 32'h04;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        rd(W_STAT, v); chk("R11 set wins", v, 32'h1C);
        wr(W_CLR, 32'h1F);
        rd(W_STAT, v); chk("R10 event flag on second step only", v, 32'h0);

        // R6/R7/R8: calendar held, time running through midnight
        load_regs(32'h00235959, mk_cal(8'h20, 8'h24, 8'h03, 3'd1, 8'h10));
        wr(W_CTRL, 32'h2);
        idle(2);
        rd(W_STAT, v); chk("R7 no ack before tick", v, 32'h0);
        wr(W_CAL, mk_cal(8'h21, 8'h05, 8'h06, 3'd3, 8'h15));
        rd(W_CAL, v);  chk("R8 calendar write before ack ignored", v, mk_cal(8'h20, 8'h24, 8'h03, 3'd1, 8'h10));
        pulse_tick();
        rd(W_STAT, v); chk("R7 R10 ack plus time events, no date event", v, 32'h0D);
        rd(W_TIME, v); chk("R6 time runs while calendar held", v, 32'h0);
        rd(W_CAL, v);  chk("R6 calendar ignores midnight carry", v, mk_cal(8'h20, 8'h24, 8'h03, 3'd1, 8'h10));
        wr(W_TIME, 32'h00112233);
        rd(W_TIME, v); chk("R8 time write without its request ignored", v, 32'h0);
        wr(W_CAL, mk_cal(8'h21, 8'h05, 8'h06, 3'd3, 8'h15));
        rd(W_CAL, v);  chk("R8 calendar write after ack taken", v, mk_cal(8'h21, 8'h05, 8'h06, 3'd3, 8'h15));
        wr(W_CTRL, 32'h0);

        // R6: time held across ticks
        wr(W_CTRL, 32'h1);
        idle(2);
        pulse_tick();
        pulse_tick();
        pulse_tick();
        rd(W_TIME, v); chk("R6 time held", v, 32'h0);
        wr(W_CTRL, 32'h0);
        idle(2);
        pulse_tick();
        rd(W_TIME, v); chk("R9 resume after release", v, 32'h00000001);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule